// File: doc/BRIEF.md
# Video Raster Timing Generator

This block produces the horizontal and vertical raster position for one display channel, running on the pixel clock. A pixel counter runs from 0 across each line, and a line counter runs from 1 down the frame. The line counter steps each time the pixel counter wraps. A horizontal blanking level is raised and lowered at two programmable pixel positions. Two single-cycle strobes mark where a downstream formatter would insert its end-of-active-video and start-of-active-video codes.

Software programs the block through two 32-bit registers: frame size, and blanking window plus a delay enable. The values written are staged. They are copied into the live configuration only at a frame boundary, so a frame never runs with mixed settings. A width or height of zero parks the counters at their starting values. When the delay enable is set, the falling edge of the blanking level comes four pixel clocks after the stop position. Every output comes straight from a flip-flop.

Top module: `vid_raster_timer`

## Requirements
- R1: After reset, pixCount is 0, lineCount is 1, hBlank, eavStrobe and savStrobe are 0, and regRdData is 0.
- R2: Register address 0 (frame size) holds the frame width in bits 11:0 and the frame height in bits 27:16. Bits 31:28 and 15:12 read as 0, and writes to them are ignored.
- R3: Register address 1 (blanking) holds the blanking start in bits 11:0, the blanking stop in bits 27:16 and the delay enable in bit 31. Bits 30:28 and 15:12 read as 0. regRdData shows the register selected by regAddr one clock after regAddr is presented.
- R4: pixCount counts 0, 1, … up to width − 1, then returns to 0.
- R5: lineCount counts 1 up to height and then returns to 1. It advances only in the cycle where pixCount returns to 0 and holds otherwise.
- R6: hBlank is 1 in every cycle where pixCount equals the blanking start.
- R7: With the delay enable clear, hBlank is 0 in every cycle where pixCount equals the blanking stop, unless stop equals start.
- R8: With the delay enable set, hBlank keeps its value at the stop position and falls four cycles later. A start position seen in those four cycles raises hBlank and cancels the pending fall. The rising edge is never delayed.
- R9: eavStrobe is 1 exactly in cycles where pixCount equals the blanking start, and savStrobe is 1 exactly where it equals the blanking stop. The delay enable does not affect either strobe.
- R10: While the live width or height is 0, pixCount stays 0, lineCount stays 1, and hBlank and both strobes stay 0.
- R11: Register writes made while the counters run take effect only from the first cycle of the next frame (pixCount 0, lineCount 1).
- R12: Standard-definition sizes work: widths 858 and 864 wrap correctly, and heights 525 and 625 wrap correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 1 | Register select: 0 frame size, 1 blanking |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data for regAddr |
| pixCount | output | 12 | Current pixel position in the line |
| lineCount | output | 12 | Current line number in the frame |
| hBlank | output | 1 | Horizontal blanking level |
| eavStrobe | output | 1 | End-of-active-video insertion strobe |
| savStrobe | output | 1 | Start-of-active-video insertion strobe |

## Verification
Some properties are checked on every cycle. The pixel position steps by one or drops to zero, and the line number holds between pixel wraps and is never zero. An end-of-active strobe always comes with blanking, and a start-of-active strobe without the delay enable always comes with blanking low. The live configuration changes only on a load cycle, and parked counters produce idle outputs.

Other behaviour only the directed scenarios can show. These are the exact wrap points for the standard-definition sizes and the four-cycle late fall of blanking, including a fall that crosses a line wrap. They also cover the deferral of new settings to the next frame, and the reserved-bit masking on readback.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  // Control strobes passed from the control unit to the datapath
  typedef struct packed {
    logic hold;      // live width or height is zero: park counters
    logic pixWrap;   // pixel counter at its last position
    logic lineWrap;  // line counter at its last line
  } vrtCtl_t;

  typedef enum logic {
    REG_FRAME = 1'b0,
    REG_BLANK = 1'b1
  } vrtReg_e;

  // Field positions inside the two 32-bit registers
  localparam int FRM_WIDTH_LSB  = 0;
  localparam int FRM_HEIGHT_LSB = 16;
  localparam int BLK_START_LSB  = 0;
  localparam int BLK_STOP_LSB   = 16;
  localparam int BLK_DLY_BIT    = 31;

endpackage

// File: rtl/vrt_ctrl.sv
module vrt_ctrl
  import vrt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [CNT_W-1:0]  pixCnt,
  input  logic [CNT_W-1:0]  lineCnt,
  output vrtCtl_t           ctl,
  output logic [CNT_W-1:0]  actStart,
  output logic [CNT_W-1:0]  actStop,
  output logic              actDly
);

  localparam logic [DATA_W-1:0] RSVD_MASK = DATA_W'(32'h7000_F000);
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);

  // Staged (programmed) values
  logic [CNT_W-1:0] progWidth, progHeight, progStart, progStop;
  logic             progDly;
  // Live values used by the counters
  logic [CNT_W-1:0] actWidth, actHeight;
  logic             running, loadCfg;
  logic [DATA_W-1:0] rdNext;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progWidth  <= '0;
      progHeight <= '0;
      progStart  <= '0;
      progStop   <= '0;
      progDly    <= 1'b0;
    end else if (regWrEn) begin
      case (vrtReg_e'(regAddr))
        REG_FRAME: begin
          progWidth  <= regWrData[FRM_WIDTH_LSB +: CNT_W];
          progHeight <= regWrData[FRM_HEIGHT_LSB +: CNT_W];
        end
        REG_BLANK: begin
          progStart  <= regWrData[BLK_START_LSB +: CNT_W];
          progStop   <= regWrData[BLK_STOP_LSB +: CNT_W];
          progDly    <= regWrData[BLK_DLY_BIT];
        end
        default: ;
      endcase
    end
  end

  // Read path: registered, reserved bits forced to zero
  always_comb begin
    rdNext = '0;
    case (vrtReg_e'(regAddr))
      REG_FRAME: begin
        rdNext[FRM_WIDTH_LSB +: CNT_W]  = progWidth;
        rdNext[FRM_HEIGHT_LSB +: CNT_W] = progHeight;
      end
      REG_BLANK: begin
        rdNext[BLK_START_LSB +: CNT_W] = progStart;
        rdNext[BLK_STOP_LSB +: CNT_W]  = progStop;
        rdNext[BLK_DLY_BIT]            = progDly;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else       regRdData <= rdNext;
  end

  // Frame boundary detection and strobe generation
  assign running     = (actWidth != '0) && (actHeight != '0);
  assign ctl.hold     = !running;
  assign ctl.pixWrap  = running && (pixCnt == actWidth - ONE);
  assign ctl.lineWrap = running && (lineCnt == actHeight);
  assign loadCfg      = !running || (ctl.pixWrap && ctl.lineWrap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actWidth  <= '0;
      actHeight <= '0;
      actStart  <= '0;
      actStop   <= '0;
      actDly    <= 1'b0;
    end else if (loadCfg) begin
      actWidth  <= progWidth;
      actHeight <= progHeight;
      actStart  <= progStart;
      actStop   <= progStop;
      actDly    <= progDly;
    end
  end

  // R11: live configuration only changes on a load cycle
  a_r11_cfg_stable: assert property (@(posedge clk) disable iff (!rstN)
    !loadCfg |=> ($stable(actWidth) && $stable(actHeight) && $stable(actStart)
                  && $stable(actStop) && $stable(actDly)));

  // R2 / R3: reserved read bits are zero
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & RSVD_MASK) == '0);

endmodule

// File: rtl/vrt_blank.sv
module vrt_blank #(
  parameter int CNT_W    = 12,
  parameter int HB_DELAY = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             running,
  input  logic [CNT_W-1:0] pixCnt,
  input  logic [CNT_W-1:0] actStart,
  input  logic [CNT_W-1:0] actStop,
  input  logic             actDly,
  output logic             hBlankOut,
  output logic             eavOut,
  output logic             savOut
);

  localparam int DLY_W = $clog2(HB_DELAY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(HB_DELAY);
  localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

  logic             startHit, stopHit;
  logic [DLY_W-1:0] pendCnt;

  assign startHit = running && (pixCnt == actStart);
  assign stopHit  = running && (pixCnt == actStop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eavOut <= 1'b0;
      savOut <= 1'b0;
    end else begin
      eavOut <= startHit;
      savOut <= stopHit;
    end
  end

  // Blanking level with optional late falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hBlankOut <= 1'b0;
      pendCnt   <= '0;
    end else if (!running) begin
      hBlankOut <= 1'b0;
      pendCnt   <= '0;
    end else if (startHit) begin
      hBlankOut <= 1'b1;
      pendCnt   <= '0;
    end else if (stopHit) begin
      if (actDly) pendCnt   <= DLY_LOAD;
      else        hBlankOut <= 1'b0;
    end else if (pendCnt != '0) begin
      pendCnt <= pendCnt - DLY_ONE;
      if (pendCnt == DLY_ONE) hBlankOut <= 1'b0;
    end
  end

  // R6: an end-of-active strobe always coincides with blanking
  a_r6_eav_blank: assert property (@(posedge clk) disable iff (!rstN)
    eavOut |-> hBlankOut);

  // R7: without delay, the stop position shows blanking low
  a_r7_sav_clear: assert property (@(posedge clk) disable iff (!rstN)
    (savOut && !eavOut && !$past(actDly)) |-> !hBlankOut);

  // R8: with delay, the stop position leaves blanking unchanged
  a_r8_sav_hold: assert property (@(posedge clk) disable iff (!rstN)
    (savOut && !eavOut && $past(actDly)) |-> (hBlankOut == $past(hBlankOut)));

endmodule

// File: rtl/vrt_datapath.sv
module vrt_datapath
  import vrt_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int HB_DELAY = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  vrtCtl_t          ctl,
  input  logic [CNT_W-1:0] actStart,
  input  logic [CNT_W-1:0] actStop,
  input  logic             actDly,
  output logic [CNT_W-1:0] pixCnt,
  output logic [CNT_W-1:0] lineCnt,
  output logic [CNT_W-1:0] pixOut,
  output logic [CNT_W-1:0] lineOut,
  output logic             hBlankOut,
  output logic             eavOut,
  output logic             savOut
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Raster counters: pixel 0-based, line 1-based
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= ONE;
    end else if (ctl.hold) begin
      pixCnt  <= '0;
      lineCnt <= ONE;
    end else if (ctl.pixWrap) begin
      pixCnt  <= '0;
      lineCnt <= ctl.lineWrap ? ONE : lineCnt + ONE;
    end else begin
      pixCnt  <= pixCnt + ONE;
    end
  end

  // Output stage aligned with the blanking unit's registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut  <= '0;
      lineOut <= ONE;
    end else begin
      pixOut  <= pixCnt;
      lineOut <= lineCnt;
    end
  end

  vrt_blank #(
    .CNT_W    (CNT_W),
    .HB_DELAY (HB_DELAY)
  ) u_blank (
    .clk       (clk),
    .rstN      (rstN),
    .running   (!ctl.hold),
    .pixCnt    (pixCnt),
    .actStart  (actStart),
    .actStop   (actStop),
    .actDly    (actDly),
    .hBlankOut (hBlankOut),
    .eavOut    (eavOut),
    .savOut    (savOut)
  );

  // R4: a nonzero pixel position is always one past the previous one
  a_r4_pix_step: assert property (@(posedge clk) disable iff (!rstN)
    (pixOut != '0) |-> (pixOut == $past(pixOut) + ONE));

  // R5: the line number holds between pixel wraps and is never zero
  a_r5_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pixOut != '0) |-> (lineOut == $past(lineOut)));
  a_r5_line_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lineOut != '0);

  // R10: parked counters give idle outputs
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> (pixOut == '0 && lineOut == ONE && !hBlankOut && !eavOut && !savOut));

endmodule

// File: rtl/vid_raster_timer.sv
module vid_raster_timer
  import vrt_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int DATA_W   = 32,
  parameter int HB_DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [CNT_W-1:0]  pixCount,
  output logic [CNT_W-1:0]  lineCount,
  output logic              hBlank,
  output logic              eavStrobe,
  output logic              savStrobe
);

  vrtCtl_t          ctl;
  logic [CNT_W-1:0] pixCnt, lineCnt, actStart, actStop;
  logic             actDly;

  vrt_ctrl #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pixCnt    (pixCnt),
    .lineCnt   (lineCnt),
    .ctl       (ctl),
    .actStart  (actStart),
    .actStop   (actStop),
    .actDly    (actDly)
  );

  vrt_datapath #(
    .CNT_W    (CNT_W),
    .HB_DELAY (HB_DELAY)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .actStart  (actStart),
    .actStop   (actStop),
    .actDly    (actDly),
    .pixCnt    (pixCnt),
    .lineCnt   (lineCnt),
    .pixOut    (pixCount),
    .lineOut   (lineCount),
    .hBlankOut (hBlank),
    .eavOut    (eavStrobe),
    .savOut    (savStrobe)
  );

endmodule

// File: tb/vid_raster_timer_tb.sv
module vid_raster_timer_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic        regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [11:0] pixCount, lineCount;
  logic        hBlank, eavStrobe, savStrobe;

  always #4 clk = ~clk;  // 125 MHz

  vid_raster_timer u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pixCount  (pixCount),
    .lineCount (lineCount),
    .hBlank    (hBlank),
    .eavStrobe (eavStrobe),
    .savStrobe (savStrobe)
  );

  int checks = 0;
  int failures = 0;

  // Reference model state (from the requirements)
  int curW, curH, curS, curP, curD;
  int nxtW, nxtH, nxtS, nxtP, nxtD;
  int expPix, expLine, expHb, pend;
  bit wrDone;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    @(negedge clk);
    v = regRdData;
  endtask

  function automatic logic [31:0] frameWord(input int w, input int h);
    return (32'(h) << 16) | 32'(w);
  endfunction

  function automatic logic [31:0] blankWord(input int s, input int p, input int d);
    return (32'(d) << 31) | (32'(p) << 16) | 32'(s);
  endfunction

  // One sampled cycle of the model, compared against the outputs
  task automatic step(input string tag);
    int e, s;
    @(negedge clk);
    if (curW == 0 || curH == 0) begin
      expPix = 0; expLine = 1; expHb = 0; pend = 0; e = 0; s = 0;
    end else begin
      e = (expPix == curS);
      s = (expPix == curP);
      if (e != 0) begin
        expHb = 1; pend = 0;
      end else if (s != 0) begin
        if (curD == 0) expHb = 0;
        else pend = 4;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) expHb = 0;
      end
    end
    chk(pixCount == 12'(expPix) && lineCount == 12'(expLine) && hBlank == expHb[0]
        && eavStrobe == e[0] && savStrobe == s[0], tag, "pix/line/hb/eav/sav",
        {pixCount, lineCount, 3'b0, hBlank, 3'b0, eavStrobe, 3'b0, savStrobe},
        {12'(expPix), 12'(expLine), 3'b0, expHb[0], 3'b0, e[0], 3'b0, s[0]});
    if (curW == 0 || curH == 0) begin
      curW = nxtW; curH = nxtH; curS = nxtS; curP = nxtP; curD = nxtD;
    end else if (expPix == curW - 1) begin
      expPix = 0;
      if (expLine == curH) begin
        expLine = 1;
        curW = nxtW; curH = nxtH; curS = nxtS; curP = nxtP; curD = nxtD;
      end else begin
        expLine++;
      end
    end else begin
      expPix++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pixCount == 12'd0, "R1", "pixCount", pixCount, 0);
    chk(lineCount == 12'd1, "R1", "lineCount", lineCount, 1);
    chk(hBlank == 1'b0, "R1", "hBlank", hBlank, 0);
    chk(eavStrobe == 1'b0 && savStrobe == 1'b0, "R1", "strobes",
        {eavStrobe, savStrobe}, 0);
    chk(regRdData == 32'd0, "R1", "regRdData", regRdData, 0);
  endtask

  task automatic held_check(input string tag);
    repeat (5) begin
      @(negedge clk);
      chk(pixCount == 12'd0 && lineCount == 12'd1 && !hBlank && !eavStrobe && !savStrobe,
          tag, "parked outputs", {pixCount, lineCount, hBlank, eavStrobe, savStrobe},
          {12'd0, 12'd1, 3'b000});
    end
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(1'b0, 32'hF000_F00A);
    rd(1'b0, v);
    chk(v == 32'h0000_000A, "R2", "frame readback (height 0)", v, 32'h0000_000A);
    held_check("R10");
    wr(1'b0, 32'hFFFF_0000);
    rd(1'b0, v);
    chk(v == 32'h0FFF_0000, "R2", "frame readback (width 0)", v, 32'h0FFF_0000);
    held_check("R10");
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, v);
    chk(v == 32'h8FFF_0FFF, "R3", "blank readback all ones", v, 32'h8FFF_0FFF);
    wr(1'b1, 32'h0000_0000);
    rd(1'b1, v);
    chk(v == 32'h0000_0000, "R3", "blank readback zero", v, 0);
  endtask

  // Start from parked counters and lock the model on pixel 1
  task automatic t_configure(input int w, input int h, input int s, input int p, input int d);
    int n = 0;
    wr(1'b1, blankWord(s, p, d));
    wr(1'b0, frameWord(w, h));
    curW = w; curH = h; curS = s; curP = p; curD = d;
    nxtW = w; nxtH = h; nxtS = s; nxtP = p; nxtD = d;
    do begin
      @(negedge clk);
      n++;
    end while (pixCount != 12'd1 && n < 40);
    chk(pixCount == 12'd1 && lineCount == 12'd1, "R4", "counters start",
        {pixCount, lineCount}, {12'd1, 12'd1});
    expPix = 2; expLine = 1; expHb = 0; pend = 0;
  endtask

  // Reprogram while running; new values must apply from the next frame
  task automatic t_switch(input int w, input int h, input int s, input int p, input int d,
                          input string tag);
    int total;
    total = curW * curH + w * h + 40;
    wrDone = 1'b0;
    fork
      begin
        int c = 0;
        while (!(wrDone && c >= total)) begin
          step(tag);
          if (wrDone) c++;
        end
      end
      begin
        while (!(expLine == 1 && expPix == 3)) @(negedge clk);
        wr(1'b1, blankWord(s, p, d));
        wr(1'b0, frameWord(w, h));
        nxtW = w; nxtH = h; nxtS = s; nxtP = p; nxtD = d;
        wrDone = 1'b1;
      end
    join
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 1'b0; regWrData = '0;
    curW = 0; curH = 0; curS = 0; curP = 0; curD = 0;
    nxtW = 0; nxtH = 0; nxtS = 0; nxtP = 0; nxtD = 0;
    expPix = 0; expLine = 1; expHb = 0; pend = 0; wrDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_configure(10, 3, 6, 9, 0);
    repeat (100) step("R4 R5 R6 R7 R9");
    t_switch(12, 4, 2, 5, 1, "R8 R11");
    t_switch(8, 2, 3, 6, 1, "R8");
    t_switch(16, 525, 4, 12, 0, "R12 R5");
    t_switch(16, 625, 4, 12, 1, "R12 R8");
    t_switch(858, 4, 720, 857, 0, "R12 R4 R7");
    t_switch(864, 3, 720, 860, 1, "R12 R8");
    t_switch(864, 0, 720, 860, 1, "R10 R11");
    held_check("R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule